// File: doc/BRIEF.md
# Programmable CPU clock prescaler

This block turns a system clock into a CPU clock enable. A byte-wide control register that software can write holds a 3-bit speed-select field, and the field picks one of eight divide ratios. The output is a one-cycle enable pulse in the system clock domain, issued once per divided period. CPU logic gates its clocked state with this pulse instead of using a second clock net.

The select encoding is not monotonic. Codes 0 to 3 give ratios of 8, 4, 2 and 1. Codes 4 to 7 give ratios of 16, 32, 128 and 256. The same table applies whatever frequency drives the system clock. After reset the field holds 2, so the CPU runs at half the system clock.

A new ratio never cuts short the period that is already running. The divider loads the new ratio only when the current period reaches its terminal count, so no period of mixed or shortened length ever appears.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: A cycle with `wr_en_i` high loads `wr_data_i[2:0]` into the select field at that clock edge. Without a write the field holds its value. Reset sets the field to 010b, and the field is visible at `rd_data_o[2:0]`.
- R2: Bits 7:3 of `rd_data_o` read as zero at all times, whatever was written to them.
- R3: Select codes 000b, 001b, 010b and 011b make the spacing between enable pulses 8, 4, 2 and 1 system clock cycles.
- R4: Select codes 100b, 101b, 110b and 111b make the spacing between enable pulses 16, 32, 128 and 256 system clock cycles.
- R5: `cpu_en_o` is high for exactly one cycle per divided period, in the last cycle of the period. At a ratio of 1 it stays high in every cycle.
- R6: After a write that changes the select field, the period in progress completes at the old ratio. Every later period uses the new ratio.
- R7: The 8-bit period counter clears on reset and never exceeds the ratio minus one. After reset is released, the first enable pulse comes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register readback |
| cpu_en_o | output | 1 | CPU clock enable pulse |

## Verification
The hardest case to reach is a write that lands at an exact position inside a running period: the boundary rule only shows if the write arrives after one terminal count and before the next. The bench synchronises to an observed enable pulse and issues the write in that same cycle. It then measures three pulse spacings: the first must match the old ratio and the next two the new ratio. This is repeated for all 64 ordered pairs of old and new code, including the ratio-1 cases where pulses arrive in every cycle.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CNT_W  = 8;
  localparam logic [SEL_W-1:0] RST_SEL = 3'b010;

  // terminal count (ratio - 1) for each select code
  function automatic logic [CNT_W-1:0] term_of(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] t;
    unique case (sel)
      3'd0: t = 8'd7;
      3'd1: t = 8'd3;
      3'd2: t = 8'd1;
      3'd3: t = 8'd0;
      3'd4: t = 8'd15;
      3'd5: t = 8'd31;
      3'd6: t = 8'd127;
      default: t = 8'd255;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/cpu_clk_ctrl_reg.sv
module cpu_clk_ctrl_reg
  import cpu_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - SEL_W;

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= RST_SEL;
    else if (wr_en_i) sel_q <= wr_data_i[SEL_W-1:0];
  end

  assign sel_o     = sel_q;
  assign rd_data_o = {{PAD_W{1'b0}}, sel_q};  // reserved bits read zero

  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (sel_q == $past(wr_data_i[SEL_W-1:0]))); // R1
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sel_q)); // R1
endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
  import cpu_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;
  logic             hit;

  assign hit = (cnt_q == term_q);

  // new ratio is adopted only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= term_of(RST_SEL);
    end else if (hit) begin
      cnt_q  <= '0;
      term_q <= term_of(sel_i);
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign en_o = hit;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_q); // R7
  AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(term_q)); // R6
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> (cnt_q == '0)); // R5
  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler
  import cpu_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cpu_en_o
);
  logic [SEL_W-1:0] sel;

  cpu_clk_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .sel_o    (sel),
    .rd_data_o(rd_data_o)
  );

  cpu_clk_divider u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .en_o  (cpu_en_o)
  );
endmodule

// File: tb/sim_cpu_clk_prescaler.sv
module sim_cpu_clk_prescaler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       cpu_en_o;

  int total = 0;
  int bad = 0;
  int cur_sel;

  always #2 clk_i = ~clk_i;

  cpu_clk_prescaler u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cpu_en_o(cpu_en_o)
  );

  function automatic int ratio_of(input int s);
    int e;
    if (s < 4) e = 3 - s;
    else       e = s + ((s >= 6) ? 1 : 0);
    return 1 << e;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count cycles to next pulse; optionally release a pending write on the first step
  task automatic next_gap(output int gap, input bit drop_wr);
    gap = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk_i);
      if (drop_wr && k == 0) wr_en_i = 1'b0;
      gap++;
      if (cpu_en_o) break;
    end
  endtask

  // called on a negedge where cpu_en_o is high
  task automatic step(input int nsel);
    int g1, g2, g3;
    wr_data_i = {5'b10101, nsel[2:0]};
    wr_en_i = 1'b1;
    next_gap(g1, 1'b1);
    check("R1 readback", rd_data_o[2:0], nsel);
    check("R2 reserved", rd_data_o[7:3], 0);
    next_gap(g2, 1'b0);
    next_gap(g3, 1'b0);
    check("R6 old period kept", g1, ratio_of(cur_sel));
    if (nsel < 4) check("R3 new ratio", g2, ratio_of(nsel));
    else          check("R4 new ratio", g2, ratio_of(nsel));
    check("R5 steady spacing", g3, ratio_of(nsel));
    cur_sel = nsel;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    bit all_high;
    repeat (3) @(negedge clk_i);
    check("R1 reset readback", rd_data_o, 8'h02);
    check("R7 held in reset", cpu_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 first pulse", cpu_en_o, 1);
    @(negedge clk_i);
    check("R5 single cycle", cpu_en_o, 0);
    @(negedge clk_i);
    check("R3 reset ratio 2", cpu_en_o, 1);
    cur_sel = 2;

    // no write: field holds, ratio unchanged
    next_gap(g, 1'b0);
    check("R1 hold ratio", g, 2);
    check("R1 hold readback", rd_data_o, 8'h02);

    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 8; n++) begin
        step(o);
        step(n);
      end

    // ratio 1: enable constantly high
    step(3);
    all_high = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (!cpu_en_o) all_high = 1'b0;
    end
    check("R5 div1 constant", all_high, 1);

    // all-ones write: reserved bits stay zero
    wr_data_i = 8'hFF;
    wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R2 all ones", rd_data_o, 8'h07);

    // reset mid-period restores defaults
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset again", rd_data_o, 8'h02);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 restart pulse", cpu_en_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule